// File: doc/BRIEF.md
# Variable-Latency Memory Port Responder

This block answers a pulse-strobe memory port from the memory side. The requester raises a one-cycle strobe along with an address, per-byte lane enables, a write flag and write data. The responder stores the request, holds it for a number of extra cycles set by a latency input, and then performs the access on a small word-addressed RAM. It marks completion with a one-cycle acknowledge pulse, and the read data is valid only during that pulse. The latency can be changed between transactions, so a core's stall handling can be tested against any response time from one cycle upward.

A second strobe may arrive before the first request has been acknowledged. A two-entry request queue holds both requests, and they are answered strictly in arrival order. The wait for a queued request starts once the request ahead of it has been serviced. A parameter selects a fetch-only variant for instruction ports, in which the write flag and write data are ignored and every request is a read.

Top module: `mem_port_responder`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `ack_o` is 0 and `rdata_o` is 0.
- R2: When the port is idle and a strobe is sampled in cycle T with `lat_i` = L, `ack_o` is high in cycle T+1+L only, and low in every cycle between.
- R3: A read (write flag 0) returns the current 32-bit word at `adr_i` on `rdata_o` in its acknowledge cycle. `rdata_o` is 0 in every cycle in which `ack_o` is low.
- R4: In a write (write flag 1), bit i of `bsel_i` enables byte lane i (bits 8i+7..8i) of the addressed word. Lanes that are not enabled keep their old value. `rdata_o` is 0 in the acknowledge cycle of a write.
- R5: A second strobe may be sampled while one request is outstanding. If request k is sampled in cycle S and the previous acknowledge falls in cycle A, request k is acknowledged in cycle max(S, A)+1+L. Acknowledges arrive in request order.
- R6: Requests take effect in arrival order, so a read queued behind a write to the same word returns the written value.
- R7: After reset, word i of the RAM holds (i × 0x01030507) XOR 0x5A5A0000, truncated to 32 bits.
- R8: With `READ_ONLY` = 1, `we_i` and `wdata_i` have no effect. Every request returns the stored word and leaves the RAM unchanged.
- R9: With L = 0, a strobe in every cycle is acknowledged one cycle after each strobe, without gaps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lat_i | input | LAT_W (4) | Extra wait cycles before each access |
| stb_i | input | 1 | One-cycle request strobe |
| we_i | input | 1 | Write flag sampled with the strobe |
| bsel_i | input | 4 | Byte lane enables |
| adr_i | input | 6 | Word address |
| wdata_i | input | 32 | Write data |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 32 | Read data, valid only while `ack_o` is high |

## Verification
If the wait counter is wrong, the next acknowledge moves by one or more cycles. The timing check at the first affected request reports this. If a queue pointer or the occupancy count is wrong, the second of an overlapping pair is answered with the wrong word, is never acknowledged, or is acknowledged twice. The bench sees each of these within L+2 cycles of the pair. A faulty lane merge or a faulty write gate is reported on the read-back that follows each write in the byte-enable sweep. Stale read data is caught in the first idle cycle, because `rdata_o` is compared with zero in every cycle without an acknowledge.

// File: rtl/mr_pkg.sv
package mr_pkg;

    localparam int unsigned MR_DATA_W = 32;
    localparam int unsigned MR_BYTES  = MR_DATA_W / 8;
    localparam int unsigned MR_ADDR_W = 6;
    localparam logic [MR_DATA_W-1:0] MR_INIT_MULT = 32'h0103_0507;

    typedef struct packed {
        logic                 wr;
        logic [MR_BYTES-1:0]  be;
        logic [MR_ADDR_W-1:0] addr;
        logic [MR_DATA_W-1:0] data;
    } mr_req_t;

    // Expand lane enables into a bit mask
    function automatic logic [MR_DATA_W-1:0] mr_lane_mask(input logic [MR_BYTES-1:0] be);
        logic [MR_DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < int'(MR_BYTES); i++) begin
            m[8*i +: 8] = {8{be[i]}};
        end
        return m;
    endfunction

    // Power-on contents of word idx
    function automatic logic [MR_DATA_W-1:0] mr_init_word(input int unsigned idx,
                                                          input logic [MR_DATA_W-1:0] seed);
        return (MR_DATA_W'(idx) * MR_INIT_MULT) ^ seed;
    endfunction

endpackage

// File: rtl/mr_req_fifo.sv
module mr_req_fifo
    import mr_pkg::*;
#(
    parameter int unsigned DEPTH = 2
) (
    input  logic    clk_i,
    input  logic    rst_ni,
    input  logic    push_i,
    input  mr_req_t push_req_i,
    input  logic    pop_i,
    output logic    empty_o,
    output logic    full_o,
    output mr_req_t head_o
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);

    typedef struct packed {
        mr_req_t [DEPTH-1:0] slot;
        logic [PTR_W-1:0]    wptr;
        logic [PTR_W-1:0]    rptr;
        logic [CNT_W-1:0]    cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        empty_o = (st_q.cnt == '0);
        full_o  = (st_q.cnt == FULL_CNT);
        head_o  = st_q.slot[st_q.rptr];
        do_pop  = pop_i && !empty_o;
        do_push = push_i && (!full_o || do_pop);

        if (do_push) begin
            st_d.slot[st_q.wptr] = push_req_i;
            st_d.wptr = (st_q.wptr == LAST_SLOT) ? '0 : st_q.wptr + 1'b1;
        end
        if (do_pop) begin
            st_d.rptr = (st_q.rptr == LAST_SLOT) ? '0 : st_q.rptr + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5: a third outstanding request never reaches a full queue
    p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (full_o && push_i) |-> pop_i);

    // R6: the sequencer only retires queued entries that exist
    p_pop_nonempty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pop_i |-> !empty_o);

endmodule

// File: rtl/mr_sequencer.sv
module mr_sequencer #(
    parameter int unsigned LAT_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             head_valid_i,
    input  logic [LAT_W-1:0] lat_i,
    output logic             fire_o
);

    typedef struct packed {
        logic [LAT_W-1:0] wait_cnt;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic    at_limit;
    logic    cnt_max;

    always_comb begin
        st_d     = st_q;
        at_limit = (st_q.wait_cnt >= lat_i);
        cnt_max  = &st_q.wait_cnt;
        fire_o   = head_valid_i && at_limit;
        if (!head_valid_i || fire_o) begin
            st_d.wait_cnt = '0;
        end else if (!cnt_max) begin
            st_d.wait_cnt = st_q.wait_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: the wait count starts from zero for every new request
    p_idle_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !head_valid_i |=> (st_q.wait_cnt == '0));

    // R2: a waiting head never counts past the programmed latency
    p_wait_bounded_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (head_valid_i && !fire_o) |=> (st_q.wait_cnt <= $past(lat_i)));

endmodule

// File: rtl/mr_word_ram.sv
module mr_word_ram
    import mr_pkg::*;
#(
    parameter int unsigned          READ_ONLY = 0,
    parameter logic [MR_DATA_W-1:0] INIT_SEED = 32'h5A5A_0000
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 acc_i,
    input  mr_req_t              req_i,
    output logic [MR_DATA_W-1:0] rdata_o
);

    localparam int unsigned DEPTH = 1 << MR_ADDR_W;

    typedef struct packed {
        logic [MR_DATA_W-1:0] rdata;
    } ram_st_t;

    ram_st_t              st_d, st_q;
    logic [MR_DATA_W-1:0] mem_q [DEPTH];
    logic                 wr_en;
    logic [MR_DATA_W-1:0] cur_word;
    logic [MR_DATA_W-1:0] lane_mask;
    logic [MR_DATA_W-1:0] merged;

    generate
        if (READ_ONLY != 0) begin : g_fetch_only
            assign wr_en = 1'b0;
        end else begin : g_read_write
            assign wr_en = acc_i && req_i.wr;
        end
    endgenerate

    always_comb begin
        cur_word   = mem_q[req_i.addr];
        lane_mask  = mr_lane_mask(req_i.be);
        merged     = (cur_word & ~lane_mask) | (req_i.data & lane_mask);
        st_d.rdata = (acc_i && !wr_en) ? cur_word : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
            for (int i = 0; i < int'(DEPTH); i++) begin
                mem_q[i] <= mr_init_word(i, INIT_SEED);
            end
        end else begin
            st_q <= st_d;
            if (wr_en) begin
                mem_q[req_i.addr] <= merged;
            end
        end
    end

    assign rdata_o = st_q.rdata;

    // R4: a write access returns no data in its completion cycle
    p_write_no_data_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_i && wr_en) |=> (rdata_o == '0));

endmodule

// File: rtl/mem_port_responder.sv
module mem_port_responder
    import mr_pkg::*;
#(
    parameter int unsigned          LAT_W     = 4,
    parameter int unsigned          READ_ONLY = 0,
    parameter logic [MR_DATA_W-1:0] INIT_SEED = 32'h5A5A_0000
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [LAT_W-1:0]     lat_i,
    input  logic                 stb_i,
    input  logic                 we_i,
    input  logic [MR_BYTES-1:0]  bsel_i,
    input  logic [MR_ADDR_W-1:0] adr_i,
    input  logic [MR_DATA_W-1:0] wdata_i,
    output logic                 ack_o,
    output logic [MR_DATA_W-1:0] rdata_o
);

    localparam int unsigned QUEUE_DEPTH = 2;

    typedef struct packed {
        logic ack;
    } top_st_t;

    top_st_t st_d, st_q;
    mr_req_t in_req;
    mr_req_t q_head;
    mr_req_t cur_req;
    logic    q_empty, q_full;
    logic    head_valid;
    logic    fire;
    logic    push, pop;

    // Incoming request; the fetch-only variant drops the write fields
    generate
        if (READ_ONLY != 0) begin : g_fetch_only
            assign in_req.wr   = 1'b0;
            assign in_req.data = '0;
        end else begin : g_read_write
            assign in_req.wr   = we_i;
            assign in_req.data = wdata_i;
        end
    endgenerate
    assign in_req.be   = bsel_i;
    assign in_req.addr = adr_i;

    // Head is the oldest queued request, or the new strobe when none waits
    always_comb begin
        head_valid = !q_empty || stb_i;
        cur_req    = q_empty ? in_req : q_head;
        push       = stb_i && !(q_empty && fire);
        pop        = fire && !q_empty;
        st_d       = st_q;
        st_d.ack   = fire;
    end

    mr_req_fifo #(
        .DEPTH (QUEUE_DEPTH)
    ) i_queue (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .push_i     (push),
        .push_req_i (in_req),
        .pop_i      (pop),
        .empty_o    (q_empty),
        .full_o     (q_full),
        .head_o     (q_head)
    );

    mr_sequencer #(
        .LAT_W (LAT_W)
    ) i_seq (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .head_valid_i (head_valid),
        .lat_i        (lat_i),
        .fire_o       (fire)
    );

    mr_word_ram #(
        .READ_ONLY (READ_ONLY),
        .INIT_SEED (INIT_SEED)
    ) i_ram (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .acc_i   (fire),
        .req_i   (cur_req),
        .rdata_o (rdata_o)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ack_o = st_q.ack;

    // R3: read data stays at zero whenever no completion is signalled
    p_idle_data_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ack_o |-> (rdata_o == '0));

    // R5: a full queue is never presented with a strobe it cannot retire
    p_queue_room_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q_full && stb_i) |-> fire);

endmodule

// File: tb/test_mem_port_responder.sv
module test_mem_port_responder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  lat = '0;
    logic        stb = 1'b0;
    logic        we = 1'b0;
    logic [3:0]  bsel = '0;
    logic [5:0]  adr = '0;
    logic [31:0] wdata = '0;
    logic        ack_m, ack_r;
    logic [31:0] rd_m, rd_r;

    always #4 clk = ~clk; // 125 MHz

    mem_port_responder #(.READ_ONLY(0)) i_mem_port_responder (
        .clk_i(clk), .rst_ni(rst_n), .lat_i(lat), .stb_i(stb), .we_i(we),
        .bsel_i(bsel), .adr_i(adr), .wdata_i(wdata), .ack_o(ack_m), .rdata_o(rd_m));

    mem_port_responder #(.READ_ONLY(1)) i_mem_port_responder_ro (
        .clk_i(clk), .rst_ni(rst_n), .lat_i(lat), .stb_i(stb), .we_i(we),
        .bsel_i(bsel), .adr_i(adr), .wdata_i(wdata), .ack_o(ack_r), .rdata_o(rd_r));

    int tick = 0;
    int n_cmp = 0;
    int n_bad = 0;
    int last_ack = 0;
    bit done = 0;
    logic [31:0] model [64];
    int          eq_tick [2][64];
    logic [31:0] eq_dat  [2][64];
    string       eq_dtag [2][64];
    string       eq_ttag [2][64];
    int          wq [2];
    int          rq [2];

    function automatic logic [31:0] init_word(input int i);
        return (32'(i) * 32'h0103_0507) ^ 32'h5A5A_0000;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s at tick %0d: actual %h expected %h", tag, what, tick, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Port monitor; p = 0 for the read-write instance, 1 for fetch-only
    task automatic mon(input int p, input logic a, input logic [31:0] d);
        int k;
        k = rq[p] % 64;
        if (a) begin
            if (rq[p] == wq[p]) begin
                check(1'b0, "R5", "unexpected ack", 32'd1, 32'd0);
            end else begin
                check(tick == eq_tick[p][k], eq_ttag[p][k], "ack cycle", 32'(tick), 32'(eq_tick[p][k]));
                check(d == eq_dat[p][k], eq_dtag[p][k], "read data", d, eq_dat[p][k]);
                rq[p]++;
            end
        end else begin
            check(d == 32'd0, "R3", "rdata outside ack", d, 32'd0);
            if (rq[p] != wq[p] && tick >= eq_tick[p][k]) begin
                check(1'b0, eq_ttag[p][k], "missing ack", 32'(tick), 32'(eq_tick[p][k]));
                rq[p]++;
            end
        end
    endtask

    always @(negedge clk) begin
        tick++;
        if (rst_n) begin
            mon(0, ack_m, rd_m);
            mon(1, ack_r, rd_r);
        end
    end

    task automatic push_exp(input int p, input int t, input logic [31:0] d,
                            input string dt, input string tt);
        eq_tick[p][wq[p] % 64] = t;
        eq_dat[p][wq[p] % 64]  = d;
        eq_dtag[p][wq[p] % 64] = dt;
        eq_ttag[p][wq[p] % 64] = tt;
        wq[p]++;
    endtask

    // Drive one strobe in the coming cycle and record expected responses
    task automatic issue(input bit w, input logic [3:0] be, input logic [5:0] a,
                         input logic [31:0] wd, input string dt, input string tt);
        logic [31:0] mask;
        int exp_t;
        @(negedge clk); #1;
        stb = 1'b1; we = w; bsel = be; adr = a; wdata = wd;
        exp_t = ((tick > last_ack) ? tick : last_ack) + 1 + int'(lat);
        last_ack = exp_t;
        mask = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
        if (w) begin
            model[a] = (model[a] & ~mask) | (wd & mask);
            push_exp(0, exp_t, 32'd0, "R4", tt);
        end else begin
            push_exp(0, exp_t, model[a], dt, tt);
        end
        push_exp(1, exp_t, init_word(int'(a)), "R8", tt);
    endtask

    task automatic quiet();
        @(negedge clk); #1;
        stb = 1'b0; we = 1'b0; bsel = '0; adr = '0; wdata = '0;
    endtask

    task automatic wait_idle();
        while (tick <= last_ack + 1) @(negedge clk);
        #1;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) model[i] = init_word(i);
        wq[0] = 0; wq[1] = 0; rq[0] = 0; rq[1] = 0;
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        check(ack_m == 1'b0 && ack_r == 1'b0, "R1", "ack in reset", 32'(ack_m), 32'd0);
        check(rd_m == 32'd0, "R1", "rdata in reset", rd_m, 32'd0);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(ack_m == 1'b0 && rd_m == 32'd0 && rd_r == 32'd0, "R1", "outputs after reset",
              rd_m, 32'd0);
        last_ack = tick;

        // R7 and R9: read every word with a strobe in every cycle at zero latency
        lat = 4'd0;
        for (int a = 0; a < 64; a++) issue(1'b0, 4'hF, 6'(a), 32'd0, "R7", "R9");
        quiet();
        wait_idle();

        // R2: latency sweep with single isolated reads
        for (int l = 0; l < 16; l++) begin
            lat = 4'(l);
            issue(1'b0, 4'hF, 6'(l * 3), 32'd0, "R3", "R2");
            quiet();
            wait_idle();
        end

        // R4 and R6: every lane pattern, write then overlapped read-back
        for (int l = 0; l < 4; l++) begin
            lat = 4'(l);
            for (int be = 0; be < 16; be++) begin
                logic [5:0] a;
                a = 6'(be * 4 + l);
                issue(1'b1, 4'(be), a, 32'hC3A5_0F69 ^ (32'(be) * 32'h1111_1111) ^ 32'(l),
                      "R4", "R5");
                issue(1'b0, 4'hF, a, 32'hFFFF_FFFF, "R6", "R5");
                quiet();
                wait_idle();
            end
        end

        // R5: second strobe at every gap up to and past the first acknowledge
        for (int l = 0; l < 5; l++) begin
            lat = 4'(l);
            for (int g = 1; g <= l + 2; g++) begin
                issue(1'b0, 4'hF, 6'(g), 32'd0, "R5", "R5");
                for (int q = 1; q < g; q++) quiet();
                issue(1'b0, 4'h3, 6'(40 + g), 32'd0, "R5", "R5");
                quiet();
                wait_idle();
            end
        end

        // R8: writes on the fetch-only instance leave its words unchanged
        lat = 4'd1;
        issue(1'b1, 4'hF, 6'd9, 32'hDEAD_BEEF, "R4", "R2");
        quiet();
        wait_idle();
        issue(1'b0, 4'hF, 6'd9, 32'd0, "R6", "R2");
        quiet();
        wait_idle();
        repeat (4) @(negedge clk);
        check(rq[0] == wq[0] && rq[1] == wq[1], "R5", "all requests answered",
              32'(rq[0]), 32'(wq[0]));
        finish_run();
    end

    initial begin
        #(8 * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

endmodule